// File: doc/BRIEF.md
# Shared Flash Ownership Arbiter

This block sits between one flash device and its two users: an embedded microcontroller and a host port on an LPC-style bus. On the microcontroller side it routes each access to one of three places. Code reads go to a scratch ROM or to the flash. Code writes always go to the flash. Data accesses in the low window go to a scratch RAM. The memory-map select bit decides which scratch area is visible. On the host side it serves each read or write according to an ownership bit, an arbitration enable and a host-wait bit. It answers the host with a 4-bit sync code.

When the microcontroller owns the flash and arbitration is on, a host read is served by holding the microcontroller clock enable low for exactly two cycles. The host reads one byte during that window. A host write made without ownership is handled in one of two ways:
- it is acknowledged at once and the flash is never touched, or
- it is parked on long-wait syncs until firmware hands the flash over.

The block also raises a host-access interrupt to the microcontroller and drives a host-flash status bit back to the host. The flash, scratch ROM and scratch RAM are external byte ports with combinational read data.

Top module: `flash_share_arbiter`

## Requirements
- R1: With memoryMap (`cfgMapRom`) = 1, a code read (`mcuData` = 0, `mcuWrite` = 0) below address 2000h is served by the scratch ROM (`romEn`, ROM address = low 13 address bits). A code read at 2000h or above is served by the flash.
- R2: With `cfgMapRom` = 0, every code read is served by the flash. A data-space access (`mcuData` = 1) below 2000h is served by the scratch RAM. A data-space access elsewhere, or any data-space access while `cfgMapRom` = 1, is not granted and touches no memory.
- R3: A code write at any address is sent to the flash under either `cfgMapRom` value, and never to the scratch ROM.
- R4: A host read that arrives while the microcontroller owns the flash (`cfgHostOwn` = 0) and arbitration is enabled holds `mcuClkEn` low for exactly two cycles. In the first of these cycles the flash is read at `hostAddr`. In the second, `hostSync` = 0000b with `hostRvalid` = 1 and the byte on `hostRdata`. A microcontroller access in the same first cycle is not granted. It is granted when the clock enable returns.
- R5: While `cfgHostOwn` = 1, a host read or write uses the flash in its first cycle and gives sync 0000b in its second, without stopping the microcontroller clock. Microcontroller flash accesses are not granted while `cfgHostOwn` = 1.
- R6: A host memory write without ownership and with `cfgHostWait` = 1 produces sync 0110b every cycle and no flash write. This lasts until `cfgHostOwn` becomes 1. In that cycle the write reaches the flash, and sync 0000b follows in the next cycle.
- R7: A host write without ownership, with either `cfgHostWait` = 0 or `hostFwh` = 1, gives sync 0000b in the next cycle and causes no flash write. This holds whatever the arbitration enable is.
- R8: A host read without ownership while arbitration is disabled is held on sync 0110b, and the microcontroller clock keeps running.
- R9: `mcuClkEn` is 0 whenever `cfgStopClk` = 1 and `sysRst` = 0. `cfgStopClk` has no effect while `sysRst` = 1.
- R10: `hostFlash` = 1 exactly when `mcuIdle` = 1, or when both `cfgMapRom` = 1 and `cfgHostOwn` = 1.
- R11: A host request accepted from idle while `cfgHostOwn` = 0 pulses `hostAccIrq` high for one cycle, in the cycle after the request appears.
- R12: After reset, and whenever no host transfer is in progress, `hostSync` = 1111b. The sync output only ever carries 0000b, 0110b or 1111b. The host holds `hostReq` until it sees 0000b and then drops it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| sysRst | input | 1 | System reset asserted (1) |
| cfgArbEn | input | 1 | Hardware read arbitration enable |
| cfgMapRom | input | 1 | Memory-map select: 1 maps scratch ROM into code space |
| cfgHostOwn | input | 1 | Ownership: 1 host, 0 microcontroller |
| cfgStopClk | input | 1 | Stop-clock request |
| cfgHostWait | input | 1 | Stall unowned host memory writes |
| mcuIdle | input | 1 | Microcontroller idle or asleep |
| mcuReq | input | 1 | Microcontroller access request |
| mcuWrite | input | 1 | Microcontroller access is a write |
| mcuData | input | 1 | 1 data space, 0 code space |
| mcuAddr | input | 16 | Microcontroller address |
| mcuWdata | input | 8 | Microcontroller write data |
| mcuGrant | output | 1 | Access served this cycle |
| mcuRdata | output | 8 | Microcontroller read data |
| mcuClkEn | output | 1 | Microcontroller clock enable |
| hostReq | input | 1 | Host transfer request |
| hostWrite | input | 1 | Host transfer is a write |
| hostFwh | input | 1 | Host transfer is a firmware-hub cycle |
| hostAddr | input | 16 | Host flash address |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Host read data |
| hostRvalid | output | 1 | Host read data valid |
| hostSync | output | 4 | Sync code to host |
| hostFlash | output | 1 | Host-flash status |
| hostAccIrq | output | 1 | Host-access interrupt pulse |
| flashEn | output | 1 | Flash access strobe |
| flashWe | output | 1 | Flash write |
| flashAddr | output | 16 | Flash address |
| flashWdata | output | 8 | Flash write data |
| flashRdata | input | 8 | Flash read data |
| romEn | output | 1 | Scratch ROM read strobe |
| romAddr | output | 13 | Scratch ROM address |
| romRdata | input | 8 | Scratch ROM data |
| ramEn | output | 1 | Scratch RAM strobe |
| ramWe | output | 1 | Scratch RAM write |
| ramAddr | output | 13 | Scratch RAM address |
| ramWdata | output | 8 | Scratch RAM write data |
| ramRdata | input | 8 | Scratch RAM data |

## Verification
Some rules are checked by assertions on every cycle:
- the stop-clock gating;
- the legal sync codes;
- the absence of any flash write while an unowned write waits;
- the shape of the two-cycle stall when it starts;
- the interrupt pulse;
- the rule that no grant is given while the clock enable is low.

Other behaviour can only be shown by the bench's scenarios, because it depends on stored flash contents and on the order of events. These are:
- that the host receives the right byte;
- that a stalled fetch is retried and then granted;
- that a waiting write lands only once ownership is given;
- that an acknowledged unowned write leaves the flash unchanged;
- that the address decode is correct across random map, space and address mixes.

// File: rtl/fsa_pkg.sv
package fsa_pkg;
  typedef enum logic [3:0] {
    SYNC_READY = 4'h0,
    SYNC_LWAIT = 4'h6,
    SYNC_NONE  = 4'hF
  } sync_e;

  typedef enum logic [1:0] {
    TGT_NONE,
    TGT_ROM,
    TGT_RAM,
    TGT_FLASH
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RESP,
    ST_WAIT
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic mcuRun;      // microcontroller clock enabled this cycle
    logic hostUse;     // host drives the flash port this cycle
    logic hostWr;      // host flash cycle is a write
    logic hostCapture; // latch flash read data for the host
  } strobes_t;
endpackage

// File: rtl/fsa_ctrl.sv
module fsa_ctrl
  import fsa_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     sysRst,
  input  logic     cfgArbEn,
  input  logic     cfgHostOwn,
  input  logic     cfgStopClk,
  input  logic     cfgHostWait,
  input  logic     hostReq,
  input  logic     hostWrite,
  input  logic     hostFwh,
  output strobes_t strb,
  output logic [3:0] hostSync,
  output logic     hostRvalid,
  output logic     hostAccIrq
);
  state_e state, nextState;
  logic respStall, nextStall;
  logic respRead, nextRead;
  logic startIrq;
  logic hostUse, hostWr, capture, stallNow;
  logic clockGate;

  always_comb begin
    nextState = state;
    nextStall = 1'b0;
    nextRead  = respRead;
    startIrq  = 1'b0;
    hostUse   = 1'b0;
    hostWr    = 1'b0;
    capture   = 1'b0;
    stallNow  = 1'b0;
    case (state)
      ST_IDLE: begin
        if (hostReq) begin
          nextRead = !hostWrite;
          startIrq = !cfgHostOwn;
          if (cfgHostOwn) begin
            hostUse   = 1'b1;
            hostWr    = hostWrite;
            capture   = !hostWrite;
            nextState = ST_RESP;
          end else if (hostWrite) begin
            // writes ignore the arbitration enable
            nextState = (hostFwh || !cfgHostWait) ? ST_RESP : ST_WAIT;
          end else if (cfgArbEn) begin
            hostUse   = 1'b1;
            capture   = 1'b1;
            stallNow  = 1'b1;
            nextStall = 1'b1;
            nextState = ST_RESP;
          end else begin
            nextState = ST_WAIT;
          end
        end
      end
      ST_WAIT: begin
        if (!hostReq) begin
          nextState = ST_IDLE;
        end else if (cfgHostOwn) begin
          hostUse   = 1'b1;
          hostWr    = hostWrite;
          capture   = !hostWrite;
          nextState = ST_RESP;
        end
      end
      ST_RESP: nextState = ST_IDLE;
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      respStall  <= 1'b0;
      respRead   <= 1'b0;
      hostAccIrq <= 1'b0;
    end else begin
      state      <= nextState;
      respStall  <= nextStall;
      respRead   <= nextRead;
      hostAccIrq <= startIrq;
    end
  end

  assign clockGate = cfgStopClk && !sysRst;

  always_comb begin
    strb.mcuRun      = !clockGate && !stallNow && !(state == ST_RESP && respStall);
    strb.hostUse     = hostUse;
    strb.hostWr      = hostWr;
    strb.hostCapture = capture;
  end

  always_comb begin
    case (state)
      ST_RESP: hostSync = SYNC_READY;
      ST_WAIT: hostSync = SYNC_LWAIT;
      default: hostSync = SYNC_NONE;
    endcase
  end

  assign hostRvalid = (state == ST_RESP) && respRead;
endmodule

// File: rtl/fsa_datapath.sv
module fsa_datapath
  import fsa_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int SCRATCH_BYTES = 8192,
  localparam int SCR_AW       = $clog2(SCRATCH_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic              cfgMapRom,
  input  logic              cfgHostOwn,
  input  logic              mcuReq,
  input  logic              mcuWrite,
  input  logic              mcuData,
  input  logic [ADDR_W-1:0] mcuAddr,
  input  logic [DATA_W-1:0] mcuWdata,
  output logic              mcuGrant,
  output logic [DATA_W-1:0] mcuRdata,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              flashEn,
  output logic              flashWe,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashWdata,
  input  logic [DATA_W-1:0] flashRdata,
  output logic              romEn,
  output logic [SCR_AW-1:0] romAddr,
  input  logic [DATA_W-1:0] romRdata,
  output logic              ramEn,
  output logic              ramWe,
  output logic [SCR_AW-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata
);
  localparam logic [ADDR_W-1:0] SCRATCH_TOP = ADDR_W'(SCRATCH_BYTES);

  tgt_e tgt;
  logic inLow, avail, mcuFlash;

  assign inLow = mcuAddr < SCRATCH_TOP;

  always_comb begin
    if (!mcuData) begin
      if (mcuWrite)               tgt = TGT_FLASH;
      else if (cfgMapRom && inLow) tgt = TGT_ROM;
      else                        tgt = TGT_FLASH;
    end else begin
      tgt = (!cfgMapRom && inLow) ? TGT_RAM : TGT_NONE;
    end
  end

  always_comb begin
    case (tgt)
      TGT_ROM, TGT_RAM: avail = 1'b1;
      TGT_FLASH:        avail = !cfgHostOwn && !strb.hostUse;
      default:          avail = 1'b0;
    endcase
  end

  assign mcuGrant = mcuReq && strb.mcuRun && avail;
  assign mcuFlash = mcuGrant && (tgt == TGT_FLASH);

  assign flashEn    = strb.hostUse || mcuFlash;
  assign flashWe    = strb.hostUse ? strb.hostWr : (mcuFlash && mcuWrite);
  assign flashAddr  = strb.hostUse ? hostAddr : mcuAddr;
  assign flashWdata = strb.hostUse ? hostWdata : mcuWdata;

  assign romEn    = mcuGrant && (tgt == TGT_ROM);
  assign romAddr  = mcuAddr[SCR_AW-1:0];
  assign ramEn    = mcuGrant && (tgt == TGT_RAM);
  assign ramWe    = ramEn && mcuWrite;
  assign ramAddr  = mcuAddr[SCR_AW-1:0];
  assign ramWdata = mcuWdata;

  always_comb begin
    case (tgt)
      TGT_ROM:   mcuRdata = romRdata;
      TGT_RAM:   mcuRdata = ramRdata;
      TGT_FLASH: mcuRdata = flashRdata;
      default:   mcuRdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 hostRdata <= '0;
    else if (strb.hostCapture) hostRdata <= flashRdata;
  end
endmodule

// File: rtl/flash_share_arbiter.sv
module flash_share_arbiter
  import fsa_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int DATA_W        = 8,
  parameter int SCRATCH_BYTES = 8192,
  localparam int SCR_AW       = $clog2(SCRATCH_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sysRst,
  input  logic              cfgArbEn,
  input  logic              cfgMapRom,
  input  logic              cfgHostOwn,
  input  logic              cfgStopClk,
  input  logic              cfgHostWait,
  input  logic              mcuIdle,
  input  logic              mcuReq,
  input  logic              mcuWrite,
  input  logic              mcuData,
  input  logic [ADDR_W-1:0] mcuAddr,
  input  logic [DATA_W-1:0] mcuWdata,
  output logic              mcuGrant,
  output logic [DATA_W-1:0] mcuRdata,
  output logic              mcuClkEn,
  input  logic              hostReq,
  input  logic              hostWrite,
  input  logic              hostFwh,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic              hostRvalid,
  output logic [3:0]        hostSync,
  output logic              hostFlash,
  output logic              hostAccIrq,
  output logic              flashEn,
  output logic              flashWe,
  output logic [ADDR_W-1:0] flashAddr,
  output logic [DATA_W-1:0] flashWdata,
  input  logic [DATA_W-1:0] flashRdata,
  output logic              romEn,
  output logic [SCR_AW-1:0] romAddr,
  input  logic [DATA_W-1:0] romRdata,
  output logic              ramEn,
  output logic              ramWe,
  output logic [SCR_AW-1:0] ramAddr,
  output logic [DATA_W-1:0] ramWdata,
  input  logic [DATA_W-1:0] ramRdata
);
  strobes_t strb;

  fsa_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .sysRst(sysRst),
    .cfgArbEn(cfgArbEn), .cfgHostOwn(cfgHostOwn), .cfgStopClk(cfgStopClk),
    .cfgHostWait(cfgHostWait), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostFwh(hostFwh), .strb(strb), .hostSync(hostSync),
    .hostRvalid(hostRvalid), .hostAccIrq(hostAccIrq)
  );

  fsa_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SCRATCH_BYTES(SCRATCH_BYTES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .cfgMapRom(cfgMapRom), .cfgHostOwn(cfgHostOwn),
    .mcuReq(mcuReq), .mcuWrite(mcuWrite), .mcuData(mcuData),
    .mcuAddr(mcuAddr), .mcuWdata(mcuWdata), .mcuGrant(mcuGrant),
    .mcuRdata(mcuRdata), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .flashEn(flashEn), .flashWe(flashWe),
    .flashAddr(flashAddr), .flashWdata(flashWdata), .flashRdata(flashRdata),
    .romEn(romEn), .romAddr(romAddr), .romRdata(romRdata),
    .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  assign mcuClkEn  = strb.mcuRun;
  assign hostFlash = mcuIdle || (cfgMapRom && cfgHostOwn);
endmodule

// File: rtl/fsa_checker.sv
module fsa_checker (
  input logic       clk,
  input logic       rstN,
  input logic       sysRst,
  input logic       cfgArbEn,
  input logic       cfgHostOwn,
  input logic       cfgStopClk,
  input logic       cfgHostWait,
  input logic       hostReq,
  input logic       hostWrite,
  input logic       hostFwh,
  input logic [3:0] hostSync,
  input logic       hostAccIrq,
  input logic       mcuGrant,
  input logic       mcuWrite,
  input logic       mcuClkEn,
  input logic       flashEn,
  input logic       flashWe
);
  logic idleStart;
  assign idleStart = hostReq && (hostSync == 4'hF);

  assert_stopclk_gates_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgStopClk && !sysRst) |-> !mcuClkEn);

  assert_sync_legal_R12: assert property (@(posedge clk) disable iff (!rstN)
    (hostSync == 4'h0) || (hostSync == 4'h6) || (hostSync == 4'hF));

  assert_stall_first_R4: assert property (@(posedge clk) disable iff (!rstN)
    (idleStart && !hostWrite && !cfgHostOwn && cfgArbEn)
      |-> (!mcuClkEn && !mcuGrant && flashEn && !flashWe));

  assert_stall_second_R4: assert property (@(posedge clk) disable iff (!rstN)
    (idleStart && !hostWrite && !cfgHostOwn && cfgArbEn)
      |=> (hostSync == 4'h0 && !mcuClkEn));

  assert_no_grant_when_stopped_R4: assert property (@(posedge clk) disable iff (!rstN)
    !mcuClkEn |-> !mcuGrant);

  assert_wait_no_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (hostSync == 4'h6 && !cfgHostOwn) |-> !(flashEn && flashWe && !mcuGrant));

  assert_silent_ack_R7: assert property (@(posedge clk) disable iff (!rstN)
    (idleStart && hostWrite && !cfgHostOwn && (hostFwh || !cfgHostWait))
      |-> (!(flashEn && flashWe && !(mcuGrant && mcuWrite)) ##1 hostSync == 4'h0));

  assert_irq_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    (idleStart && !cfgHostOwn) |=> hostAccIrq);
endmodule

bind flash_share_arbiter fsa_checker i_fsa_checker (
  .clk(clk), .rstN(rstN), .sysRst(sysRst), .cfgArbEn(cfgArbEn),
  .cfgHostOwn(cfgHostOwn), .cfgStopClk(cfgStopClk), .cfgHostWait(cfgHostWait),
  .hostReq(hostReq), .hostWrite(hostWrite), .hostFwh(hostFwh),
  .hostSync(hostSync), .hostAccIrq(hostAccIrq), .mcuGrant(mcuGrant),
  .mcuWrite(mcuWrite), .mcuClkEn(mcuClkEn), .flashEn(flashEn), .flashWe(flashWe)
);

// File: tb/test_flash_share_arbiter.sv
module test_flash_share_arbiter;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sysRst = 1'b0;
  logic cfgArbEn = 1'b0, cfgMapRom = 1'b0, cfgHostOwn = 1'b0;
  logic cfgStopClk = 1'b0, cfgHostWait = 1'b0, mcuIdle = 1'b0;
  logic mcuReq = 1'b0, mcuWrite = 1'b0, mcuData = 1'b0;
  logic [15:0] mcuAddr = '0;
  logic [7:0] mcuWdata = '0;
  logic mcuGrant, mcuClkEn;
  logic [7:0] mcuRdata;
  logic hostReq = 1'b0, hostWrite = 1'b0, hostFwh = 1'b0;
  logic [15:0] hostAddr = '0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic hostRvalid, hostFlash, hostAccIrq;
  logic [3:0] hostSync;
  logic flashEn, flashWe;
  logic [15:0] flashAddr;
  logic [7:0] flashWdata, flashRdata;
  logic romEn, ramEn, ramWe;
  logic [12:0] romAddr, ramAddr;
  logic [7:0] romRdata, ramRdata, ramWdata;

  logic [7:0] flashMem [256];
  logic [7:0] ramMem [256];

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_share_arbiter i_flash_share_arbiter (
    .clk(clk), .rstN(rstN), .sysRst(sysRst), .cfgArbEn(cfgArbEn),
    .cfgMapRom(cfgMapRom), .cfgHostOwn(cfgHostOwn), .cfgStopClk(cfgStopClk),
    .cfgHostWait(cfgHostWait), .mcuIdle(mcuIdle), .mcuReq(mcuReq),
    .mcuWrite(mcuWrite), .mcuData(mcuData), .mcuAddr(mcuAddr),
    .mcuWdata(mcuWdata), .mcuGrant(mcuGrant), .mcuRdata(mcuRdata),
    .mcuClkEn(mcuClkEn), .hostReq(hostReq), .hostWrite(hostWrite),
    .hostFwh(hostFwh), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .hostRvalid(hostRvalid), .hostSync(hostSync),
    .hostFlash(hostFlash), .hostAccIrq(hostAccIrq), .flashEn(flashEn),
    .flashWe(flashWe), .flashAddr(flashAddr), .flashWdata(flashWdata),
    .flashRdata(flashRdata), .romEn(romEn), .romAddr(romAddr),
    .romRdata(romRdata), .ramEn(ramEn), .ramWe(ramWe), .ramAddr(ramAddr),
    .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  // memory models
  assign flashRdata = flashMem[flashAddr[7:0]];
  assign romRdata   = romAddr[7:0] ^ 8'h5A;
  assign ramRdata   = ramMem[ramAddr[7:0]];

  always @(posedge clk) begin
    if (flashEn && flashWe) flashMem[flashAddr[7:0]] <= flashWdata;
    if (ramEn && ramWe) ramMem[ramAddr[7:0]] <= ramWdata;
  end

  // expected target: 0 none, 1 rom, 2 ram, 3 flash
  function automatic int expTarget(bit mapRom, bit own, bit isData, bit isWr, logic [15:0] a);
    int t;
    if (!isData) t = isWr ? 3 : ((mapRom && a < 16'h2000) ? 1 : 3);
    else t = (!mapRom && a < 16'h2000) ? 2 : 0;
    if (t == 3 && own) t = 0;
    return t;
  endfunction

  function automatic logic [7:0] expRead(int t, logic [15:0] a);
    case (t)
      1: return a[7:0] ^ 8'h5A;
      2: return ramMem[a[7:0]];
      3: return flashMem[a[7:0]];
      default: return 8'h00;
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] oldVal;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < 256; i++) begin
      flashMem[i] = 8'(i * 7 + 3);
      ramMem[i] = 8'(i ^ 8'hC3);
    end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R12 reset state
    @(negedge clk);
    check(hostSync == 4'hF, "R12 idle sync", 32'(hostSync), 32'hF);
    check(mcuClkEn == 1'b1, "R12 clock runs", 32'(mcuClkEn), 1);
    check(hostAccIrq == 1'b0, "R12 no irq", 32'(hostAccIrq), 0);

    // R1 R2 R3 random decode
    for (int i = 0; i < 400; i++) begin
      int t;
      tick();
      cfgMapRom = 1'($urandom);
      cfgHostOwn = ($urandom % 4) == 0;
      mcuData = 1'($urandom);
      mcuWrite = 1'($urandom);
      mcuReq = 1'b1;
      mcuAddr = ($urandom % 2) ? 16'($urandom % 8192) : 16'(16'h2000 + $urandom % 16'hE000);
      if (i < 4) mcuAddr = (i % 2) ? 16'h1FFF : 16'h2000;
      mcuWdata = 8'($urandom);
      @(negedge clk);
      t = expTarget(cfgMapRom, cfgHostOwn, mcuData, mcuWrite, mcuAddr);
      check((flashEn ? 3 : ramEn ? 2 : romEn ? 1 : 0) == t,
            mcuData ? "R2 data decode" : (mcuWrite ? "R3 code write decode" : "R1 code read decode"),
            32'(flashEn ? 3 : ramEn ? 2 : romEn ? 1 : 0), 32'(t));
      check(mcuGrant == (t != 0), "R2 grant", 32'(mcuGrant), 32'(t != 0));
      if (!mcuWrite && t != 0)
        check(mcuRdata == expRead(t, mcuAddr), "R1 read data", 32'(mcuRdata), 32'(expRead(t, mcuAddr)));
      if (mcuWrite && t == 3)
        check(flashWe && flashAddr == mcuAddr && flashWdata == mcuWdata, "R3 flash write", 32'(flashAddr), 32'(mcuAddr));
    end

    // R4 two-cycle stall, host wins, mcu retried
    tick();
    cfgHostOwn = 1'b0; cfgArbEn = 1'b1; cfgMapRom = 1'b0;
    mcuReq = 1'b1; mcuWrite = 1'b0; mcuData = 1'b0; mcuAddr = 16'h4010;
    hostReq = 1'b1; hostWrite = 1'b0; hostAddr = 16'h0033;
    @(negedge clk);
    check(!mcuClkEn && !mcuGrant, "R4 stall cycle one", 32'({mcuClkEn, mcuGrant}), 0);
    check(flashEn && !flashWe && flashAddr == 16'h0033, "R4 host flash read", 32'(flashAddr), 32'h33);
    tick();
    @(negedge clk);
    check(hostSync == 4'h0 && hostRvalid, "R4 ready sync", 32'(hostSync), 0);
    check(hostRdata == flashMem[8'h33], "R4 host data", 32'(hostRdata), 32'(flashMem[8'h33]));
    check(!mcuClkEn, "R4 stall cycle two", 32'(mcuClkEn), 0);
    check(hostAccIrq, "R11 irq pulse", 32'(hostAccIrq), 1);
    tick();
    hostReq = 1'b0;
    @(negedge clk);
    check(mcuClkEn && mcuGrant, "R4 fetch retried", 32'({mcuClkEn, mcuGrant}), 3);
    check(mcuRdata == flashMem[8'h10], "R4 retry data", 32'(mcuRdata), 32'(flashMem[8'h10]));
    check(!hostAccIrq && hostSync == 4'hF, "R11 single pulse", 32'(hostAccIrq), 0);

    // R5 host owns: read then write, no stall
    tick();
    cfgHostOwn = 1'b1; cfgArbEn = 1'b0; cfgMapRom = 1'b1; mcuAddr = 16'h4020;
    hostReq = 1'b1; hostWrite = 1'b0; hostAddr = 16'h0044;
    @(negedge clk);
    check(mcuClkEn && !mcuGrant, "R5 no stall, mcu flash blocked", 32'({mcuClkEn, mcuGrant}), 2);
    check(flashEn && flashAddr == 16'h0044, "R5 host read", 32'(flashAddr), 32'h44);
    tick();
    @(negedge clk);
    check(hostSync == 4'h0 && hostRdata == flashMem[8'h44], "R5 read data", 32'(hostRdata), 32'(flashMem[8'h44]));
    check(!hostAccIrq, "R11 no irq when host owns", 32'(hostAccIrq), 0);
    tick();
    hostReq = 1'b0; mcuReq = 1'b0;
    tick();
    hostReq = 1'b1; hostWrite = 1'b1; hostAddr = 16'h0050; hostWdata = 8'hC3;
    @(negedge clk);
    check(flashEn && flashWe && flashAddr == 16'h0050, "R5 host write", 32'(flashAddr), 32'h50);
    tick();
    @(negedge clk);
    check(hostSync == 4'h0 && !hostRvalid, "R5 write ready", 32'(hostSync), 0);
    tick();
    hostReq = 1'b0;
    @(negedge clk);
    check(flashMem[8'h50] == 8'hC3, "R5 flash written", 32'(flashMem[8'h50]), 32'hC3);

    // R6 wait bit: long-wait until ownership
    tick();
    cfgHostOwn = 1'b0; cfgHostWait = 1'b1; cfgArbEn = 1'b1;
    hostReq = 1'b1; hostWrite = 1'b1; hostAddr = 16'h0060; hostWdata = 8'h3C;
    for (int k = 0; k < 4; k++) begin
      tick();
      @(negedge clk);
      check(hostSync == 4'h6 && !(flashEn && flashWe), "R6 long wait", 32'(hostSync), 32'h6);
    end
    tick();
    cfgHostOwn = 1'b1;
    @(negedge clk);
    check(flashEn && flashWe && flashAddr == 16'h0060, "R6 write on grant", 32'(flashAddr), 32'h60);
    tick();
    @(negedge clk);
    check(hostSync == 4'h0, "R6 ready after grant", 32'(hostSync), 0);
    tick();
    hostReq = 1'b0;
    @(negedge clk);
    check(flashMem[8'h60] == 8'h3C, "R6 flash data", 32'(flashMem[8'h60]), 32'h3C);

    // R7 silent acknowledge: wait clear, then firmware-hub write
    for (int k = 0; k < 2; k++) begin
      tick();
      cfgHostOwn = 1'b0; cfgArbEn = 1'b1;
      cfgHostWait = (k == 1); hostFwh = (k == 1);
      hostAddr = 16'h0070; hostWdata = 8'h11; hostWrite = 1'b1; hostReq = 1'b1;
      oldVal = flashMem[8'h70];
      @(negedge clk);
      check(!flashEn && mcuClkEn, "R7 no flash cycle", 32'(flashEn), 0);
      tick();
      @(negedge clk);
      check(hostSync == 4'h0, "R7 ready sync", 32'(hostSync), 0);
      tick();
      hostReq = 1'b0; hostFwh = 1'b0;
      @(negedge clk);
      check(flashMem[8'h70] == oldVal, "R7 flash unchanged", 32'(flashMem[8'h70]), 32'(oldVal));
    end

    // R8 read without ownership, arbitration off
    tick();
    cfgArbEn = 1'b0; cfgHostOwn = 1'b0; hostWrite = 1'b0; hostReq = 1'b1;
    for (int k = 0; k < 3; k++) begin
      tick();
      @(negedge clk);
      check(hostSync == 4'h6 && mcuClkEn, "R8 read held", 32'(hostSync), 32'h6);
    end
    tick();
    hostReq = 1'b0;
    tick();
    @(negedge clk);
    check(hostSync == 4'hF, "R12 back to idle", 32'(hostSync), 32'hF);

    // R9 stop clock gated by system reset
    tick();
    cfgStopClk = 1'b1; sysRst = 1'b0;
    @(negedge clk);
    check(!mcuClkEn, "R9 clock stopped", 32'(mcuClkEn), 0);
    tick();
    sysRst = 1'b1;
    @(negedge clk);
    check(mcuClkEn, "R9 reset overrides stop", 32'(mcuClkEn), 1);
    tick();
    cfgStopClk = 1'b0; sysRst = 1'b0;

    // R10 host-flash status
    for (int k = 0; k < 8; k++) begin
      tick();
      mcuIdle = k[0]; cfgMapRom = k[1]; cfgHostOwn = k[2];
      @(negedge clk);
      check(hostFlash == (k[0] || (k[1] && k[2])), "R10 status", 32'(hostFlash), 32'(k[0] || (k[1] && k[2])));
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule